// File: doc/BRIEF.md
# Double-Edge Input Capture with Half-Rate Resync

This block is the receive datapath for one source-synchronous data pin. A strobe clock arrives with the data. The block samples the serial bit on the strobe's rising edge and again on its falling edge. It moves the falling-edge sample back into the rising-edge domain, so that each rising-edge sample and the falling-edge sample that follows it form one aligned pair. The aligned pairs go into a four-entry asynchronous FIFO. A half-rate system clock reads two pairs at a time from that FIFO, so the core receives a 4-bit word on every read-clock cycle.

The falling-edge register can be clocked in two ways. It can use the falling edge of the main strobe, or it can use the rising edge of a separate complementary strobe. Both strobes can be inverted before capture, which suits memory interfaces that deliver their strobes in the opposite sense. Two bypasses are available. The first skips the dual-edge capture, so each pair carries the rising-edge sample twice. The second skips the FIFO, so the aligned pair appears directly at the output.

Top module: `ddr_in_capture`

## Requirements
- R1: Each 4-bit output word holds two pairs with the oldest sample first. Bit 0 is the rising-edge sample of the older pair and bit 1 is the falling-edge sample that follows it. Bits 2 and 3 hold the newer pair in the same order.
- R2: With `fall_src` low, the falling-edge sample is taken on the falling edge of the (possibly inverted) main strobe, and `strb_c` has no effect.
- R3: With `fall_src` high, the falling-edge sample is taken only on the rising edge of the (possibly inverted) `strb_c`. If `strb_c` does not toggle, every odd output bit reads 0.
- R4: With `strb_flip` high, both strobes are inverted before capture. The captured data is then the same as with `strb_flip` low and the strobes driven in the opposite sense.
- R5: With `cap_bypass` high, both bits of each pair carry the rising-edge sample. The word order of R1 still applies.
- R6: With `fifo_bypass` high, `par_out` equals {2'b00, falling sample, rising sample} of the aligned pair. It updates on every rising strobe edge.
- R7: On each rising `hclk` edge at which the FIFO holds at least two pairs, one word is read. `empty` is high whenever fewer than two pairs are visible to the read side.
- R8: While `empty` is high, the FIFO-side word at `par_out` holds its last value.
- R9: `full` is high when four pairs are stored. A pair that arrives while `full` is high is dropped, and `overflow` goes high and stays high until the capture reset.
- R10: After reset, `par_out` is 0, `empty` is 1, `full` is 0 and `overflow` is 0.
- R11: After `cap_rst_n` is released, the first two strobe cycles are discarded. The first pair stored is the one captured in the third strobe cycle, and the aligned pair reads 0 until then.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cap_rst_n | input | 1 | Active-low reset of the capture domain; asynchronous assert, released on the strobe |
| strb_p | input | 1 | Main strobe; its rising edge clocks the capture side |
| strb_c | input | 1 | Complementary strobe, used for falling-edge capture when `fall_src` is high |
| fall_src | input | 1 | Falling-edge clock source: 0 = inverted main strobe, 1 = complementary strobe |
| strb_flip | input | 1 | Inverts both strobes before capture |
| ser_in | input | 1 | Serial data bit |
| cap_bypass | input | 1 | Skips dual-edge capture; the rising-edge sample fills both pair bits |
| fifo_bypass | input | 1 | Skips the FIFO; the aligned pair drives the output |
| hclk | input | 1 | Half-rate read clock |
| hrst_n | input | 1 | Active-low reset of the read domain; asynchronous assert, synchronous release |
| par_out | output | 4 | Parallel word toward the core |
| empty | output | 1 | Fewer than two pairs are available (read domain) |
| full | output | 1 | FIFO holds four pairs (capture domain) |
| overflow | output | 1 | Sticky flag: a pair was dropped because the FIFO was full |

## Verification
The bench builds the block with its default depth of four pairs. With that depth, a single burst of six pairs, sent while the read side is held in reset, is enough to fill the FIFO, raise `full` and drop two pairs into the sticky `overflow` flag. Four-pair bursts then fit exactly into one half-full-to-drained cycle. These bursts exercise every combination of strobe inversion, falling-edge source and capture bypass, so each can be compared against the same two expected words.

// File: rtl/ddr_in_capture.sv
`timescale 1ns/1ps
module ddr_in_capture #(
  parameter int DEPTH = 4
) (
  input  logic       cap_rst_n,
  input  logic       strb_p,
  input  logic       strb_c,
  input  logic       fall_src,
  input  logic       strb_flip,
  input  logic       ser_in,
  input  logic       cap_bypass,
  input  logic       fifo_bypass,
  input  logic       hclk,
  input  logic       hrst_n,
  output logic [3:0] par_out,
  output logic       empty,
  output logic       full,
  output logic       overflow
);
  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;

  function automatic logic [PW-1:0] g2b(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic rclk, fclk;
  assign rclk = strb_p ^ strb_flip;
  assign fclk = fall_src ? (strb_c ^ strb_flip) : ~rclk;

  logic [1:0] crst_q;
  logic       crst_n;
  always_ff @(posedge rclk or negedge cap_rst_n)
    if (!cap_rst_n) crst_q <= '0;
    else            crst_q <= {crst_q[0], 1'b1};
  assign crst_n = crst_q[1];

  logic neg_q;
  always_ff @(posedge fclk or negedge crst_n)
    if (!crst_n) neg_q <= 1'b0;
    else         neg_q <= ser_in;

  logic pos_q, pos_vld, pr_r, pr_f, pr_vld;
  always_ff @(posedge rclk or negedge crst_n)
    if (!crst_n) begin
      pos_q   <= 1'b0;
      pos_vld <= 1'b0;
      pr_r    <= 1'b0;
      pr_f    <= 1'b0;
      pr_vld  <= 1'b0;
    end else begin
      pos_q   <= ser_in;
      pos_vld <= 1'b1;
      pr_r    <= pos_q;
      pr_f    <= cap_bypass ? pos_q : neg_q;
      pr_vld  <= pos_vld;
    end

  logic [1:0]    mem [DEPTH];
  logic [PW-1:0] wptr, wnext, wgray, rs_bin, wfill;
  logic [AW-1:0] rg_s1, rg_s2;

  assign wnext  = wptr + 1'b1;
  assign rs_bin = g2b({1'b0, rg_s2});
  assign wfill  = wptr - (rs_bin << 1);
  assign full   = (wfill == PW'(DEPTH));

  always_ff @(posedge rclk or negedge crst_n)
    if (!crst_n) begin
      wptr     <= '0;
      wgray    <= '0;
      overflow <= 1'b0;
      rg_s1    <= '0;
      rg_s2    <= '0;
    end else begin
      rg_s1 <= rgray;
      rg_s2 <= rg_s1;
      if (pr_vld) begin
        if (full) overflow <= 1'b1;
        else begin
          wptr  <= wnext;
          wgray <= wnext ^ (wnext >> 1);
        end
      end
    end

  always_ff @(posedge rclk)
    if (crst_n && pr_vld && !full) mem[wptr[AW-1:0]] <= {pr_f, pr_r};

  logic [1:0]    hrst_q;
  logic          hrst_s;
  logic [PW-1:0] wg_s1, wg_s2, wseen, rfill;
  logic [AW-1:0] rword, rnext, rgray, ridx_lo, ridx_hi;
  logic [3:0]    word_q;

  always_ff @(posedge hclk or negedge hrst_n)
    if (!hrst_n) hrst_q <= '0;
    else         hrst_q <= {hrst_q[0], 1'b1};
  assign hrst_s = hrst_q[1];

  assign wseen   = g2b(wg_s2);
  assign rfill   = wseen - {rword, 1'b0};
  assign empty   = (rfill < PW'(2));
  assign rnext   = rword + 1'b1;
  assign ridx_lo = {rword[AW-2:0], 1'b0};
  assign ridx_hi = {rword[AW-2:0], 1'b1};

  always_ff @(posedge hclk or negedge hrst_s)
    if (!hrst_s) begin
      wg_s1  <= '0;
      wg_s2  <= '0;
      rword  <= '0;
      rgray  <= '0;
      word_q <= '0;
    end else begin
      wg_s1 <= wgray;
      wg_s2 <= wg_s1;
      if (!empty) begin
        word_q <= {mem[ridx_hi], mem[ridx_lo]};
        rword  <= rnext;
        rgray  <= rnext ^ (rnext >> 1);
      end
    end

  assign par_out = fifo_bypass ? {2'b00, pr_f, pr_r} : word_q;

  assert_wgray_step_R7: assert property (@(posedge rclk) disable iff (!crst_n)
    $countones(wgray ^ $past(wgray)) <= 1);
  assert_rgray_step_R7: assert property (@(posedge hclk) disable iff (!hrst_s)
    $countones(rgray ^ $past(rgray)) <= 1);
  assert_no_overfill_R9: assert property (@(posedge rclk) disable iff (!crst_n)
    wfill <= PW'(DEPTH));
  assert_read_bound_R7: assert property (@(posedge hclk) disable iff (!hrst_s)
    rfill <= PW'(DEPTH));
  assert_ovf_sticky_R9: assert property (@(posedge rclk) disable iff (!crst_n)
    overflow |=> overflow);
  assert_empty_hold_R8: assert property (@(posedge hclk) disable iff (!hrst_s)
    empty |=> $stable(word_q));
endmodule

// File: tb/sim_ddr_in_capture.sv
`timescale 1ns/1ps
module sim_ddr_in_capture;
  logic cap_rst_n = 1'b0, hrst_n = 1'b0, hclk = 1'b0;
  logic v = 1'b0, strb_flip = 1'b0, fall_src = 1'b0, c_mode = 1'b0, c_level = 1'b1;
  logic ser_in = 1'b0, cap_bypass = 1'b0, fifo_bypass = 1'b0;
  logic strb_p, strb_c;
  logic [3:0] par_out;
  logic empty, full, overflow;
  int checks = 0, errors = 0;
  logic collect = 1'b0, prev_ne = 1'b0;
  logic [3:0] got [8];
  int got_n = 0;

  assign strb_p = v ^ strb_flip;
  assign strb_c = c_mode ? ~strb_p : c_level;

  ddr_in_capture u0 (
    .cap_rst_n(cap_rst_n), .strb_p(strb_p), .strb_c(strb_c), .fall_src(fall_src),
    .strb_flip(strb_flip), .ser_in(ser_in), .cap_bypass(cap_bypass),
    .fifo_bypass(fifo_bypass), .hclk(hclk), .hrst_n(hrst_n), .par_out(par_out),
    .empty(empty), .full(full), .overflow(overflow));

  always #5 hclk = ~hclk;

  always @(negedge hclk) begin
    if (!collect) begin
      got_n = 0;
      prev_ne = 1'b0;
    end else begin
      if (prev_ne && got_n < 8) begin
        got[got_n] = par_out;
        got_n++;
      end
      prev_ne = !empty;
    end
  end

  // {stream[7:0] (bit i = time i), flip, fall_src, c_mode, cap_bypass, word0, word1}
  localparam logic [19:0] VEC [7] = '{
    {8'b1011_0010, 4'b0000, 4'b0010, 4'b1011},
    {8'b0110_1001, 4'b1000, 4'b1001, 4'b0110},
    {8'b1100_0111, 4'b0110, 4'b0111, 4'b1100},
    {8'b0101_1110, 4'b1110, 4'b1110, 4'b0101},
    {8'b1111_1111, 4'b0100, 4'b0101, 4'b0101},
    {8'b1001_0110, 4'b0001, 4'b1100, 4'b0011},
    {8'b0011_0101, 4'b1001, 4'b1111, 4'b0011}
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic half_rise(input logic a);
    ser_in = a; #1.25 v = 1'b1; #1.25;
  endtask
  task automatic half_fall(input logic b);
    ser_in = b; #1.25 v = 1'b0; #1.25;
  endtask
  task automatic cyc(input logic a, input logic b);
    half_rise(a);
    half_fall(b);
  endtask

  task automatic start(input logic hold_rd);
    collect = 1'b0; cap_rst_n = 1'b0; hrst_n = 1'b0; v = 1'b0;
    @(negedge hclk);
    #20 cap_rst_n = 1'b1; hrst_n = !hold_rd; collect = 1'b1;
    #20;
  endtask

  initial begin
    #2000000;
    checks++; errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    // R10: reset state
    #40;
    chk("R10 par_out", 8'(par_out), 8'h0);
    chk("R10 empty", 8'(empty), 8'h1);
    chk("R10 full", 8'(full), 8'h0);
    chk("R10 overflow", 8'(overflow), 8'h0);

    // R1 R2 R3 R4 R5 vector table
    foreach (VEC[k]) begin
      strb_flip = VEC[k][11]; fall_src = VEC[k][10]; c_mode = VEC[k][9]; cap_bypass = VEC[k][8];
      start(1'b0);
      cyc(1'b1, 1'b1); cyc(1'b1, 1'b1);              // R11 discarded cycles
      for (int i = 0; i < 4; i++) cyc(VEC[k][12+2*i], VEC[k][13+2*i]);
      cyc(1'b1, 1'b1); cyc(1'b1, 1'b1);
      #200;
      chk($sformatf("R1/R4/R5 vec%0d count", k), 8'(got_n), 8'd2);
      chk($sformatf("R1 R2 R3 vec%0d word0", k), 8'(got[0]), 8'(VEC[k][7:4]));
      chk($sformatf("R1 R2 R3 vec%0d word1", k), 8'(got[1]), 8'(VEC[k][3:0]));
      chk($sformatf("R7 vec%0d empty after drain", k), 8'(empty), 8'h1);
    end
    strb_flip = 1'b0; fall_src = 1'b0; c_mode = 1'b0; cap_bypass = 1'b0;

    // R6 and R11 with the FIFO bypassed
    fifo_bypass = 1'b1;
    start(1'b0);
    cyc(1'b1, 1'b1);
    half_rise(1'b1);
    chk("R11 pair still cleared", 8'(par_out), 8'h0);
    half_fall(1'b1);
    cyc(1'b0, 1'b1);
    half_rise(1'b1);
    chk("R6 bypass pair a", 8'(par_out), 8'b0010);
    half_fall(1'b1);
    half_rise(1'b0);
    chk("R6 bypass pair b", 8'(par_out), 8'b0011);
    half_fall(1'b0);
    fifo_bypass = 1'b0;

    // R9 overflow with the read side held in reset
    start(1'b1);
    cyc(1'b1, 1'b1); cyc(1'b1, 1'b1);
    cyc(1'b1, 1'b0); cyc(1'b1, 1'b1); cyc(1'b0, 1'b1);
    cyc(1'b0, 1'b0); cyc(1'b1, 1'b1); cyc(1'b1, 1'b1);
    cyc(1'b0, 1'b0); cyc(1'b0, 1'b0);
    #20;
    chk("R9 full", 8'(full), 8'h1);
    chk("R9 overflow set", 8'(overflow), 8'h1);
    hrst_n = 1'b1;
    #200;
    chk("R9 words kept", 8'(got_n), 8'd2);
    chk("R9 word0", 8'(got[0]), 8'b1101);
    chk("R9 word1", 8'(got[1]), 8'b0010);
    chk("R9 overflow sticky", 8'(overflow), 8'h1);
    #100;
    chk("R8 hold while empty", 8'(par_out), 8'b0010);
    chk("R7 empty", 8'(empty), 8'h1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule